// File: doc/BRIEF.md
# Phase-Edge Blanking Timer

This block builds the window during which one bridge channel ignores its current-sense comparator. Switching the bridge direction, or starting a new chop period, produces a current spike that would trip the comparator falsely; the timer masks the comparator across that disturbance. The direction request arrives on an asynchronous input. The block synchronises it, detects both of its edges, issues a counter-reset pulse that clears the chop timing, and masks the comparator from the moment the edge is seen until a programmable serial-blanking interval has elapsed.

Timing is counted in reference ticks. The reference tick is a one-cycle enable at sixteen times the chop rate. A three-bit code selects the serial-blanking length. The same code also sets a blanking window at the start of every chop period; a free-running counter, cleared by the counter-reset pulse, marks those period starts. The synchronised direction is passed straight out, so the bridge turns over at once and the mask only hides the comparator while it does.

Top module: `phase_blank_timer`

## Requirements
- R1: A change on `phase_i` reaches `dir_o` and raises `blank_o` exactly SYNC_STAGES clock cycles later (default 2).
- R2: Each edge of the synchronised direction, rising or falling, asserts `cnt_rst_o` starting the next cycle. It stays high across exactly RST_TICKS reference ticks (default 2) and falls on the clock that consumes the last of them.
- R3: `blank_o` is high in the cycle the edge is detected and throughout the counter reset. The serial window is never active while `cnt_rst_o` is high, and it begins in the cycle right after the reset ends, so the mask has no gap.
- R4: After an edge, the serial window lasts code+1 reference ticks, where code is the unsigned value of `blank_code_i` (0 to 7).
- R5: With a tick on every cycle, the mask after an edge is one contiguous run of code+4 cycles: 1 edge cycle, 2 reset cycles and code+1 serial cycles.
- R6: The chop counter restarts at zero when the counter reset ends. Every CHOP_DIV ticks (default 16) it opens another serial window of code+1 ticks. With a tick on every cycle, that window begins CHOP_DIV cycles after the edge-triggered serial window began.
- R7: `cmp_masked_o` equals `cmp_i` while `blank_o` is low, and is 0 while `blank_o` is high.
- R8: `dir_o` takes the new direction in the same cycle that blanking starts. Blanking does not delay it.
- R9: The code is captured when a serial window opens. A change of `blank_code_i` during the window does not change that window's length, but it does apply to the next window.
- R10: During and right after reset, `cnt_rst_o`, `blank_o` and `dir_o` are 0, and `cmp_masked_o` follows `cmp_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Reference tick enable, 16 per chop period |
| phase_i | input | 1 | Asynchronous direction request |
| blank_code_i | input | CODE_W | Serial-blanking code, length = code+1 ticks |
| cmp_i | input | 1 | Raw current comparator result |
| cnt_rst_o | output | 1 | Counter-reset pulse after a direction edge |
| blank_o | output | 1 | Combined phase-blank and serial-blank mask |
| cmp_masked_o | output | 1 | Comparator result with the mask applied |
| dir_o | output | 1 | Synchronised direction for the bridge |

## Verification
The bench sweeps all eight codes on both rising and falling edges. For each case it measures the synchroniser latency, the reset pulse width, the length of the contiguous mask and the spacing to the next chop-start window. A design with an off-by-one serial counter, or with a gap between the reset and the serial window, gives a mask run one cycle off, or broken in two. A design that reacts to one edge polarity only shows no reset pulse on half of the cases. Sparse ticks check that the reset spans two ticks and not two clocks; a pulse counted in clocks would be far too short. A code change in the middle of a window checks that the length was captured at the start; a design that reads the code live would cut the window short.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

   // Counter width for a modulus of n (at least one bit).
   function automatic int cnt_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/pbt_sync.sv
module pbt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   initial begin
      assert (STAGES >= 2) else $error("pbt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/pbt_edge_reset.sv
module pbt_edge_reset #(
   parameter int RST_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic lvl_i,
   output logic edge_o,
   output logic rst_o,
   output logic done_o
);
   localparam int W = pbt_pkg::cnt_w(RST_TICKS);
   localparam logic [W-1:0] LAST = W'(RST_TICKS - 1);

   initial begin
      assert (RST_TICKS >= 1) else $error("pbt_edge_reset: RST_TICKS must be positive");
   end

   logic         lvl_d;
   logic         active;
   logic [W-1:0] rcnt;

   assign edge_o = lvl_i ^ lvl_d;
   assign rst_o  = active;
   assign done_o = active & tick_i & ~edge_o & (rcnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d  <= 1'b0;
         active <= 1'b0;
         rcnt   <= '0;
      end else begin
         lvl_d <= lvl_i;
         if (edge_o) begin
            active <= 1'b1;
            rcnt   <= '0;
         end else if (active && tick_i) begin
            if (rcnt == LAST) active <= 1'b0;
            else              rcnt   <= rcnt + 1'b1;
         end
      end
   end

   AST_EDGE_ARMS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> rst_o);                                    // R2
   AST_RESET_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_o) |-> $past(tick_i));                      // R2
endmodule

// File: rtl/pbt_chop_counter.sv
module pbt_chop_counter #(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic clr_i,
   output logic wrap_o
);
   localparam int W = pbt_pkg::cnt_w(DIV);
   localparam logic [W-1:0] LAST = W'(DIV - 1);

   initial begin
      assert (DIV >= 2) else $error("pbt_chop_counter: DIV must be at least 2");
   end

   logic [W-1:0] cnt;

   assign wrap_o = tick_i & ~clr_i & (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr_i)  cnt <= '0;
      else if (tick_i) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   AST_CHOP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);                                         // R6
   AST_CHOP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt == '0));                               // R6
endmodule

// File: rtl/pbt_serial_window.sv
module pbt_serial_window #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              on_o
);
   initial begin
      assert (CODE_W >= 1 && CODE_W <= 8) else $error("pbt_serial_window: CODE_W out of range");
   end

   logic              on_q;
   logic [CODE_W-1:0] bcnt;
   logic [CODE_W-1:0] code_q;

   assign on_o = on_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q   <= 1'b0;
         bcnt   <= '0;
         code_q <= '0;
      end else if (abort_i) begin
         on_q <= 1'b0;
      end else if (start_i) begin
         on_q   <= 1'b1;
         bcnt   <= '0;
         code_q <= code_i;
      end else if (on_q && tick_i) begin
         if (bcnt == code_q) on_q <= 1'b0;
         else                bcnt <= bcnt + 1'b1;
      end
   end

   AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      on_q |-> (bcnt <= code_q));                           // R4
   AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (on_q && $past(on_q) && !$past(start_i)) |-> $stable(code_q)); // R9
   AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> !on_q);                                   // R3
endmodule

// File: rtl/phase_blank_timer.sv
module phase_blank_timer #(
   parameter int SYNC_STAGES = 2,
   parameter int RST_TICKS   = 2,
   parameter int CHOP_DIV    = 16,
   parameter int CODE_W      = 3,
   parameter bit CHOP_REARM  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick_i,
   input  logic              phase_i,
   input  logic [CODE_W-1:0] blank_code_i,
   input  logic              cmp_i,
   output logic              cnt_rst_o,
   output logic              blank_o,
   output logic              cmp_masked_o,
   output logic              dir_o
);
   logic ph_sync;
   logic edge_det;
   logic rst_act;
   logic rst_done;
   logic win_start;
   logic ser_on;

   pbt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (phase_i),
      .sync_o  (ph_sync)
   );

   pbt_edge_reset #(.RST_TICKS(RST_TICKS)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (ref_tick_i),
      .lvl_i  (ph_sync),
      .edge_o (edge_det),
      .rst_o  (rst_act),
      .done_o (rst_done)
   );

   generate
      if (CHOP_REARM) begin : g_rearm
         logic chop_wrap;
         pbt_chop_counter #(.DIV(CHOP_DIV)) u_chop (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (ref_tick_i),
            .clr_i  (rst_act | edge_det),
            .wrap_o (chop_wrap)
         );
         assign win_start = rst_done | chop_wrap;
      end else begin : g_edge_only
         assign win_start = rst_done;
      end
   endgenerate

   pbt_serial_window #(.CODE_W(CODE_W)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (ref_tick_i),
      .start_i (win_start),
      .abort_i (edge_det),
      .code_i  (blank_code_i),
      .on_o    (ser_on)
   );

   assign cnt_rst_o    = rst_act;
   assign blank_o      = edge_det | rst_act | ser_on;
   assign cmp_masked_o = cmp_i & ~blank_o;
   assign dir_o        = ph_sync;

   AST_NO_SERIAL_DURING_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      rst_act |-> !ser_on);                                 // R3
   AST_RESET_HANDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rst_act) && !edge_det) |-> ser_on);            // R3
   AST_DIR_MOVES_UNDER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dir_o) |-> blank_o);                         // R8
endmodule

// File: tb/phase_blank_timer_bench.sv
module phase_blank_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick;
   logic       phase;
   logic [2:0] code;
   logic       cmp;
   logic       cnt_rst_o, blank_o, cmp_masked_o, dir_o;

   always #4 clk = ~clk;

   phase_blank_timer u_phase_blank_timer (
      .clk (clk), .rst_n (rst_n), .ref_tick_i (tick), .phase_i (phase),
      .blank_code_i (code), .cmp_i (cmp), .cnt_rst_o (cnt_rst_o),
      .blank_o (blank_o), .cmp_masked_o (cmp_masked_o), .dir_o (dir_o)
   );

   int n_chk = 0, n_fail = 0;
   int tick_div = 1, tcnt = 0;
   bit bl [0:40];
   bit rs [0:40];
   bit dr [0:40];
   bit cm [0:40];
   bit tk [0:40];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      if (tick_div <= 1) tick = 1'b1;
      else begin
         tcnt = (tcnt + 1) % tick_div;
         tick = (tcnt == 0);
      end
   endtask

   function automatic int run_len(input int from);
      int n = 0;
      for (int i = from; i <= 40 && bl[i]; i++) n++;
      return n;
   endfunction

   // Toggle phase at a falling edge, then record 40 cycles.
   task automatic capture(input int change_at, input logic [2:0] new_code);
      step();
      phase = ~phase;
      for (int s = 1; s <= 40; s++) begin
         step();
         bl[s] = blank_o; rs[s] = cnt_rst_o; dr[s] = dir_o; cm[s] = cmp_masked_o;
         tk[s] = tick;
         if (s == change_at) code = new_code;
      end
   endtask

   task automatic sweep_case(input logic [2:0] c);
      int nrs = 0, cmp_bad = 0;
      code = c;
      capture(0, c);
      chk(dr[1] != phase && dr[2] == phase, "R1 dir latency", dr[2], phase);
      chk(bl[1] == 0 || bl[2] == 1, "R1 mask latency", bl[2], 1);
      chk(bl[2] == 1 && rs[2] == 0, "R3 edge cycle masked before reset", rs[2], 0);
      for (int s = 1; s <= 20; s++) nrs += rs[s];
      chk(nrs == 2 && rs[3] && rs[4], "R2 reset pulse width", nrs, 2);
      chk(run_len(2) == c + 4, "R5 contiguous mask", run_len(2), c + 4);
      chk(run_len(5) == c + 1, "R4 serial window length", run_len(5), c + 1);
      chk(bl[20] == 0 && bl[21] == 1 && run_len(21) == c + 1,
          "R6 chop-start window", run_len(21), c + 1);
      chk(dr[2] == phase && bl[2], "R8 dir under mask", dr[2], phase);
      for (int s = 1; s <= 40; s++) if (cm[s] != !bl[s]) cmp_bad++;
      chk(cmp_bad == 0 && cm[13] == 1, "R7 comparator masking", cmp_bad, 0);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int nrs, ntk;
      rst_n = 1'b0; tick = 1'b1; phase = 1'b0; code = 3'd0; cmp = 1'b1;
      repeat (3) step();
      chk(!cnt_rst_o && !blank_o && !dir_o && cmp_masked_o, "R10 reset state",
          {cnt_rst_o, blank_o, dir_o, cmp_masked_o}, 4'b0001);
      rst_n = 1'b1;
      step();
      chk(!cnt_rst_o && !blank_o && !dir_o && cmp_masked_o, "R10 after release",
          {cnt_rst_o, blank_o, dir_o, cmp_masked_o}, 4'b0001);
      cmp = 1'b0;
      step();
      chk(cmp_masked_o == 0, "R7 low comparator passes", cmp_masked_o, 0);
      cmp = 1'b1;

      // Both edge polarities across every code.
      for (int c = 0; c < 8; c++) begin
         sweep_case(3'(c));   // rising or falling, alternating
         sweep_case(3'(c));
      end

      // R9: code changed in the middle of a window.
      code = 3'd6;
      capture(6, 3'd0);
      chk(run_len(5) == 7, "R9 window keeps captured code", run_len(5), 7);
      chk(run_len(21) == 1, "R9 next window uses new code", run_len(21), 1);

      // R2: sparse ticks, reset spans two ticks.
      tick_div = 3; tcnt = 0; code = 3'd0;
      capture(0, 3'd0);
      nrs = 0; ntk = 0;
      for (int s = 1; s <= 40; s++) if (rs[s]) begin nrs++; ntk += tk[s]; end
      chk(ntk == 2, "R2 reset spans two ticks", ntk, 2);
      chk(nrs >= 4 && nrs <= 6, "R2 reset width in clocks", nrs, 5);
      tick_div = 1;

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule